// File: doc/BRIEF.md
# CCD Exposure Shutter Controller

This block decides, line by line, whether the sensor's substrate discharge pulse is issued, and so sets the exposure time of a CCD camera. The sync generator supplies a one-cycle line strobe, a one-cycle field strobe and a strobe marking the fall of the charge readout pulse. The block returns a per-line discharge enable and, for long exposures, the number of fields to hold off readout.

There are three ways to set the exposure. In preset mode the three configuration pins carry a code that selects one of eight fixed speeds. In serial mode the same pins act as strobe, shift clock and data, and load a 9-bit load value plus a 2-bit shutter type. In trigger mode an external active-low pulse ends the discharge interval that the readout edge opened. A master enable overrides all three. Preset and serial settings take effect at the next field strobe.

Top module: `eshutter_ctrl`

## Requirements
- R1: While `shut_en` is low, `xsub_en` is 0 and `skip_fields` is 0, whatever the mode and settings.
- R2: With `par_sel` high, the code `cfg_pins[2:0]` selects an exposure of E lines and discharge is issued on lines 0 to F-E-1 of the field. F is 262 with `std_625` low and 312 with it high. The codes map as 000→1, 100→3, 010→7, 110→15, 001→31 and 101→62 lines.
- R3: In preset mode, code 111 means shutter off, with no discharge on any line. Code 011 gives 157 lines when `std_625` is low and shutter off when it is high.
- R4: In serial mode, `cfg_pins[2]` is data and is shifted on each rising edge of `cfg_pins[1]`. A frame is 12 bits: load bits 0 to 8 (bit 0 first), then type bit A, then type bit B, then a filler bit. Only the last 12 bits shifted are kept.
- R5: The shifted frame becomes the pending setting only while the strobe `cfg_pins[0]` is low. Preset and serial settings reach the outputs only at the next `field_stb`.
- R6: Type {A,B}=01 (fast): discharge is issued on lines with index below 511-L. For a large enough field, this gives an exposure of F-(511-L) lines.
- R7: Type 00 (flicker-free): the exposure is 157 lines when `std_625` is low and 130 lines when it is high, so discharge covers lines below F minus that count.
- R8: Type 10 (slow): `skip_fields` = 2×(511-L) and no discharge is issued.
- R9: Type 11 (none), and type 10 with L = 0x1FF, give no discharge and `skip_fields` = 0.
- R10: With `trig_mode` high, `xsub_en` goes high on the cycle after a `rdout_fall` strobe. It goes low on the third clock edge after `trig_n` falls, and stays low until the next `rdout_fall`.
- R11: `field_stb` sets the line index to 0, and each `line_stb` advances it by one. The discharge window counts from that index.
- R12: After reset, `xsub_en` and `skip_fields` are 0 and the pending serial setting is type 11.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shut_en | input | 1 | Master shutter enable; low suppresses discharge |
| par_sel | input | 1 | High: preset code; low: serial load |
| std_625 | input | 1 | Low: 525-line timing; high: 625-line timing |
| cfg_pins | input | 3 | Preset code, or serial strobe [0], shift clock [1], data [2] |
| trig_n | input | 1 | Active-low exposure end trigger |
| trig_mode | input | 1 | Selects trigger-gated discharge |
| line_stb | input | 1 | One-cycle strobe at each line start |
| field_stb | input | 1 | One-cycle strobe at each field start |
| rdout_fall | input | 1 | One-cycle strobe at the readout pulse fall |
| xsub_en | output | 1 | Discharge enable for the current line |
| skip_fields | output | 10 | Field hold-off count for slow exposure |

## Verification
A corrupted line index or threshold changes how many lines of a field carry discharge, and the per-field count of enabled lines shows this within that same field. A wrong shift order or a pending setting captured at the wrong time gives a wrong discharge window or hold-off count. This appears at the first field strobe after the strobe pulse. A fault in the trigger gate shows in the cycle-exact comparison within three cycles of a trigger or readout edge.

// File: rtl/esc_pkg.sv
// Shared definitions for the exposure shutter controller.
// Assumes the configuration pins are bit 0 strobe, bit 1 shift clock, bit 2 data.
package esc_pkg;

    localparam int PIN_STB = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_DAT = 2;

    // Shutter type carried in the serial frame, written {A,B}.
    typedef enum logic [1:0] {
        SM_FLICKER = 2'b00,
        SM_FAST    = 2'b01,
        SM_SLOW    = 2'b10,
        SM_NONE    = 2'b11
    } ser_mode_e;

    // Exposure in lines for a preset code; 0 means shutter off.
    function automatic int preset_lines(input logic [2:0] code, input logic s625,
                                        input int flk_lines);
        int e;
        case (code)
            3'b000:  e = 1;
            3'b100:  e = 3;
            3'b010:  e = 7;
            3'b110:  e = 15;
            3'b001:  e = 31;
            3'b101:  e = 62;
            3'b011:  e = s625 ? 0 : flk_lines;
            default: e = 0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/esc_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes STAGES >= 2; the output lags the pin by STAGES clock edges.
module esc_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Purpose: move pin values through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{IDLE}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/esc_serial.sv
// Serial frame receiver. Shifts data on rising edges of the synchronized
// shift clock and copies the frame to the pending setting while the strobe is low.
// Assumes synchronized inputs; a strobe shorter than a clock may go unseen.
module esc_serial
    import esc_pkg::*;
#(
    parameter int LOAD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_lvl,
    input  logic              dat_lvl,
    input  logic              stb_lvl,
    output logic [LOAD_W-1:0] pend_load,
    output ser_mode_e         pend_mode
);

    localparam int FRAME_W = LOAD_W + 3;

    logic [FRAME_W-1:0] sr;
    logic               clk_prev;
    logic               shift_now;

    assign shift_now = clk_lvl & ~clk_prev;

    // Purpose: detect shift clock rises and shift the frame toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '1;
            clk_prev <= 1'b0;
        end else begin
            clk_prev <= clk_lvl;
            if (shift_now) sr <= {dat_lvl, sr[FRAME_W-1:1]};
        end
    end

    // Purpose: copy the frame to the pending setting while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_load <= '1;
            pend_mode <= SM_NONE;
        end else if (!stb_lvl) begin
            pend_load <= sr[LOAD_W-1:0];
            pend_mode <= ser_mode_e'({sr[LOAD_W], sr[LOAD_W+1]});
        end
    end

endmodule

// File: rtl/esc_setting.sv
// Converts a preset code or the pending serial setting into a discharge
// line threshold and a field hold-off count. Latches both at the field strobe.
// Assumes the field line counts fit in LOAD_W bits.
module esc_setting
    import esc_pkg::*;
#(
    parameter int LOAD_W    = 9,
    parameter int LINES_525 = 262,
    parameter int LINES_625 = 312,
    parameter int FLK_525   = 157,
    parameter int FLK_625   = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              par_sel,
    input  logic              std_625,
    input  logic [2:0]        code,
    input  logic [LOAD_W-1:0] pend_load,
    input  ser_mode_e         pend_mode,
    output logic [LOAD_W-1:0] thr,
    output logic [LOAD_W:0]   skip
);

    localparam logic [LOAD_W-1:0] LOAD_MAX = '1;

    logic [LOAD_W-1:0] lines_f;
    logic [LOAD_W-1:0] expo;
    logic [LOAD_W-1:0] thr_d;
    logic [LOAD_W:0]   skip_d;

    // Purpose: work out the setting that the next field will use.
    always_comb begin
        lines_f = std_625 ? LOAD_W'(LINES_625) : LOAD_W'(LINES_525);
        expo    = LOAD_W'(preset_lines(code, std_625, FLK_525));
        thr_d   = '0;
        skip_d  = '0;
        if (par_sel) begin
            if (expo != '0) thr_d = lines_f - expo;
        end else begin
            case (pend_mode)
                SM_FLICKER: thr_d = lines_f - (std_625 ? LOAD_W'(FLK_625) : LOAD_W'(FLK_525));
                SM_FAST:    thr_d = LOAD_MAX - pend_load;
                SM_SLOW:    if (pend_load != LOAD_MAX) skip_d = {LOAD_MAX - pend_load, 1'b0};
                default:    ;
            endcase
        end
    end

    // Purpose: apply the new setting only at a field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr  <= '0;
            skip <= '0;
        end else if (field_stb) begin
            thr  <= thr_d;
            skip <= skip_d;
        end
    end

endmodule

// File: rtl/esc_timing.sv
// Line index counter, trigger gate and output gating.
// Assumes one-cycle strobes from the sync generator; the field strobe wins over the line strobe.
module esc_timing #(
    parameter int LOAD_W = 9,
    parameter int LCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              field_stb,
    input  logic              rdout_fall,
    input  logic              trig_lvl,
    input  logic              trig_mode,
    input  logic              shut_en,
    input  logic [LOAD_W-1:0] thr,
    input  logic [LOAD_W:0]   skip,
    output logic              xsub_en,
    output logic [LOAD_W:0]   skip_fields
);

    localparam logic [LCNT_W-1:0] LCNT_MAX = '1;

    logic [LCNT_W-1:0] lcnt;
    logic              gate;
    logic              trig_prev;

    // Purpose: count lines from the field start, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                               lcnt <= '0;
        else if (field_stb)                       lcnt <= '0;
        else if (line_stb && lcnt != LCNT_MAX)    lcnt <= lcnt + 1'b1;
    end

    // Purpose: open the trigger gate at readout, close it on a trigger fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate      <= 1'b0;
            trig_prev <= 1'b1;
        end else begin
            trig_prev <= trig_lvl;
            if (rdout_fall)                 gate <= 1'b1;
            else if (trig_prev && !trig_lvl) gate <= 1'b0;
        end
    end

    // Purpose: combine the mode, window and master enable into the outputs.
    always_comb begin
        xsub_en     = shut_en & (trig_mode ? gate : (lcnt < LCNT_W'(thr)));
        skip_fields = shut_en ? skip : '0;
    end

endmodule

// File: rtl/eshutter_ctrl.sv
// Exposure shutter controller top. Synchronizes the configuration and trigger
// pins, decodes the setting and gates the per-line discharge.
// Assumes the line, field and readout strobes are synchronous and one cycle wide.
module eshutter_ctrl
    import esc_pkg::*;
#(
    parameter int LOAD_W      = 9,
    parameter int LCNT_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int LINES_525   = 262,
    parameter int LINES_625   = 312,
    parameter int FLK_525     = 157,
    parameter int FLK_625     = 130
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shut_en,
    input  logic            par_sel,
    input  logic            std_625,
    input  logic [2:0]      cfg_pins,
    input  logic            trig_n,
    input  logic            trig_mode,
    input  logic            line_stb,
    input  logic            field_stb,
    input  logic            rdout_fall,
    output logic            xsub_en,
    output logic [LOAD_W:0] skip_fields
);

    logic [2:0]        cfg_q;
    logic              trig_q;
    logic [LOAD_W-1:0] pend_load;
    ser_mode_e         pend_mode;
    logic [LOAD_W-1:0] thr;
    logic [LOAD_W:0]   skip;

    esc_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)) u_cfg_sync (
        .clk(clk), .rst_n(rst_n), .d(cfg_pins), .q(cfg_q)
    );

    esc_sync #(.W(1), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .d(trig_n), .q(trig_q)
    );

    esc_serial #(.LOAD_W(LOAD_W)) u_serial (
        .clk(clk), .rst_n(rst_n),
        .clk_lvl(cfg_q[PIN_CLK]), .dat_lvl(cfg_q[PIN_DAT]), .stb_lvl(cfg_q[PIN_STB]),
        .pend_load(pend_load), .pend_mode(pend_mode)
    );

    esc_setting #(
        .LOAD_W(LOAD_W), .LINES_525(LINES_525), .LINES_625(LINES_625),
        .FLK_525(FLK_525), .FLK_625(FLK_625)
    ) u_setting (
        .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .par_sel(par_sel),
        .std_625(std_625), .code(cfg_q), .pend_load(pend_load), .pend_mode(pend_mode),
        .thr(thr), .skip(skip)
    );

    esc_timing #(.LOAD_W(LOAD_W), .LCNT_W(LCNT_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
        .rdout_fall(rdout_fall), .trig_lvl(trig_q), .trig_mode(trig_mode),
        .shut_en(shut_en), .thr(thr), .skip(skip),
        .xsub_en(xsub_en), .skip_fields(skip_fields)
    );

endmodule

// File: rtl/esc_checker.sv
// Property checker for the exposure shutter controller, bound to the top.
// Assumes it observes only the top-level ports.
module esc_checker #(
    parameter int SKIP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shut_en,
    input logic              trig_mode,
    input logic              rdout_fall,
    input logic              field_stb,
    input logic              xsub_en,
    input logic [SKIP_W-1:0] skip_fields
);

    // R1: the master enable low silences both outputs.
    a_r1_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_en |-> (!xsub_en && skip_fields == '0));

    // R8: the hold-off count is twice a field difference, so it is always even.
    a_r8_skip_even: assert property (@(posedge clk) disable iff (!rst_n)
        skip_fields[0] == 1'b0);

    // R8: a slow exposure never issues discharge outside trigger mode.
    a_r8_slow_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_mode && skip_fields != '0) |-> !xsub_en);

    // R5: the hold-off count changes only after a field strobe.
    a_r5_field_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_en && !field_stb) |=> (!shut_en || $stable(skip_fields)));

    // R10: a readout strobe opens the trigger gate.
    a_r10_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode && rdout_fall) |=> (!shut_en || !trig_mode || xsub_en));

endmodule

bind eshutter_ctrl esc_checker #(.SKIP_W(LOAD_W + 1)) u_esc_checker (
    .clk(clk), .rst_n(rst_n), .shut_en(shut_en), .trig_mode(trig_mode),
    .rdout_fall(rdout_fall), .field_stb(field_stb), .xsub_en(xsub_en),
    .skip_fields(skip_fields)
);

// File: tb/test_eshutter_ctrl.sv
`timescale 1ns/1ps
// Bench for the exposure shutter controller: behavioural model compared every cycle,
// plus per-field counts of discharge lines checked against the requirement formulas.
module test_eshutter_ctrl;

    logic       clk = 1'b0;
    logic       rst_n, shut_en, par_sel, std_625, trig_n, trig_mode;
    logic       line_stb, field_stb, rdout_fall;
    logic [2:0] cfg_pins;
    logic       xsub_en;
    logic [9:0] skip_fields;

    always #2.5 clk = ~clk;

    eshutter_ctrl i_eshutter_ctrl (
        .clk(clk), .rst_n(rst_n), .shut_en(shut_en), .par_sel(par_sel), .std_625(std_625),
        .cfg_pins(cfg_pins), .trig_n(trig_n), .trig_mode(trig_mode), .line_stb(line_stb),
        .field_stb(field_stb), .rdout_fall(rdout_fall), .xsub_en(xsub_en),
        .skip_fields(skip_fields)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;
    bit    started = 0;
    string phase = "R12";

    // Behavioural model state
    int       m_lcnt, m_thr, m_skip, m_pload, m_pmode;
    bit       m_gate;
    bit [2:0] cfg_hist[$];
    bit       trig_hist[$];
    bit       sbits[$];

    // Requirement formulas R2, R3, R6-R9: discharge threshold and hold-off count.
    function automatic void want(input bit par, input bit [2:0] code, input int load,
                                 input int mode, input bit s625,
                                 output int thr, output int skip);
        int f = s625 ? 312 : 262;
        int e;
        thr = 0; skip = 0;
        if (par) begin
            case (code)
                3'b000: e = 1;   3'b100: e = 3;   3'b010: e = 7;  3'b110: e = 15;
                3'b001: e = 31;  3'b101: e = 62;
                3'b011: e = s625 ? 0 : 157;
                default: e = 0;
            endcase
            if (e > 0) thr = f - e;
        end else begin
            case (mode)
                0: thr = f - (s625 ? 130 : 157);
                1: thr = 511 - load;
                2: if (load != 511) skip = 2 * (511 - load);
                default: ;
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cfg_hist  = '{3'b001, 3'b001, 3'b001};
            trig_hist = '{1'b1, 1'b1, 1'b1};
            sbits = {};
            for (int i = 0; i < 12; i++) sbits.push_back(1'b1);
            m_pload = 511; m_pmode = 3; m_thr = 0; m_skip = 0; m_gate = 0; m_lcnt = 0;
            started = 1;
        end else begin
            bit [2:0] cs, cp;
            bit       ts, tp;
            cfg_hist.push_back(cfg_pins);
            trig_hist.push_back(trig_n);
            cs = cfg_hist[cfg_hist.size()-3];
            cp = cfg_hist[cfg_hist.size()-4];
            ts = trig_hist[trig_hist.size()-3];
            tp = trig_hist[trig_hist.size()-4];
            if (cfg_hist.size() > 6) begin
                void'(cfg_hist.pop_front());
                void'(trig_hist.pop_front());
            end
            if (rdout_fall) m_gate = 1;
            else if (tp && !ts) m_gate = 0;
            if (field_stb) begin
                want(par_sel, cs, m_pload, m_pmode, std_625, m_thr, m_skip);
                m_lcnt = 0;
            end else if (line_stb && m_lcnt < 1023) begin
                m_lcnt++;
            end
            if (!cs[0]) begin
                m_pload = 0;
                for (int i = 0; i < 9; i++) if (sbits[i]) m_pload += (1 << i);
                m_pmode = (sbits[9] ? 2 : 0) + (sbits[10] ? 1 : 0);
            end
            if (cs[1] && !cp[1]) begin
                sbits.push_back(cs[2]);
                void'(sbits.pop_front());
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            bit exp_x;
            int exp_s;
            #1;
            exp_x = shut_en && (trig_mode ? m_gate : (m_lcnt < m_thr));
            exp_s = shut_en ? m_skip : 0;
            vectors++;
            if (xsub_en !== exp_x || skip_fields !== 10'(exp_s)) begin
                miscompares++;
                $display("FAIL %s cycle compare: xsub=%b skip=%0d expected xsub=%b skip=%0d",
                         phase, xsub_en, skip_fields, exp_x, exp_s);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run one field of n lines and count lines carrying discharge.
    task automatic run_field(input int n, input string req, input int exp_lines);
        int seen = 0;
        phase = req;
        field_stb = 1'b1; cyc(1); field_stb = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (xsub_en) seen++;
            line_stb = (i < n - 1); cyc(1); line_stb = 1'b0;
        end
        chk(req, seen, exp_lines);
    endtask

    task automatic put_bit(input bit b);
        cfg_pins[2] = b; cyc(3);
        cfg_pins[1] = 1'b1; cyc(3);
        cfg_pins[1] = 1'b0; cyc(3);
    endtask

    task automatic ser_shift(input int load, input int mode, input int junk);
        for (int j = 0; j < junk; j++) put_bit(1'b1);
        for (int i = 0; i < 9; i++) put_bit(load[i]);
        put_bit(mode[1]); put_bit(mode[0]); put_bit(1'b0);
    endtask

    task automatic ser_strobe;
        cfg_pins[0] = 1'b0; cyc(4);
        cfg_pins[0] = 1'b1; cyc(4);
    endtask

    function automatic int clip(input int t, input int n);
        return (t < n) ? t : n;
    endfunction

    initial begin
        int t, s;
        rst_n = 0; shut_en = 1; par_sel = 1; std_625 = 0; cfg_pins = 3'b001;
        trig_n = 1; trig_mode = 0; line_stb = 0; field_stb = 0; rdout_fall = 0;
        cyc(4);
        chk("R12", xsub_en, 0); chk("R12", skip_fields, 0);
        rst_n = 1; cyc(2);
        chk("R12", xsub_en, 0); chk("R12", skip_fields, 0);

        // R2 / R3: preset codes, 525-line timing
        for (int c = 0; c < 8; c++) begin
            cfg_pins = 3'(c); cyc(4);
            want(1, 3'(c), 0, 0, 0, t, s);
            run_field(262, (c == 7 || c == 3) ? "R3" : "R2", clip(t, 262));
        end
        // R3 / R2: 625-line timing
        std_625 = 1;
        cfg_pins = 3'b011; cyc(4); run_field(312, "R3", 0);
        cfg_pins = 3'b000; cyc(4); run_field(312, "R2", 311);
        std_625 = 0;

        // Serial mode
        par_sel = 0; cfg_pins = 3'b001; cyc(4);
        ser_shift(9'h1A5, 1, 0);
        run_field(262, "R5", 0);                    // not strobed yet: still no shutter
        ser_strobe;
        run_field(262, "R4", 511 - 9'h1A5);         // 90 lines, bit order check
        ser_shift(9'h1F0, 1, 2); ser_strobe;        // two extra leading bits dropped
        run_field(262, "R4", 15);
        ser_shift(0, 1, 0); ser_strobe;
        run_field(262, "R6", 262);                  // window beyond field: every line
        ser_shift(0, 0, 0); ser_strobe;
        run_field(262, "R7", 262 - 157);
        std_625 = 1; cyc(4);
        run_field(312, "R7", 312 - 130);
        std_625 = 0;
        ser_shift(9'h1FE, 2, 0); ser_strobe;
        run_field(262, "R8", 0); chk("R8", skip_fields, 2);
        ser_shift(9'h100, 2, 0); ser_strobe;
        run_field(262, "R8", 0); chk("R8", skip_fields, 510);
        ser_shift(9'h1FF, 2, 0); ser_strobe;
        chk("R5", skip_fields, 510);                // before the field strobe
        run_field(262, "R9", 0); chk("R9", skip_fields, 0);
        ser_shift(9'h0F0, 3, 0); ser_strobe;
        run_field(262, "R9", 0); chk("R9", skip_fields, 0);

        // R1: master enable
        ser_shift(9'h1FE, 2, 0); ser_strobe;
        run_field(262, "R8", 0); chk("R8", skip_fields, 2);
        phase = "R1";
        shut_en = 0; cyc(1); chk("R1", skip_fields, 0);
        ser_shift(0, 1, 0); ser_strobe;
        run_field(262, "R1", 0);
        shut_en = 1; cyc(2);

        // R11: line index restarts at each field strobe
        ser_shift(9'h1F0, 1, 0); ser_strobe;
        run_field(40, "R11", 15);
        run_field(10, "R11", 10);

        // R10: trigger gate
        phase = "R10";
        trig_mode = 1; cyc(2); chk("R10", xsub_en, 0);
        rdout_fall = 1; cyc(1); rdout_fall = 0; chk("R10", xsub_en, 1);
        cyc(5); chk("R10", xsub_en, 1);
        trig_n = 0; cyc(2); chk("R10", xsub_en, 1);
        cyc(1); chk("R10", xsub_en, 0);
        trig_n = 1; cyc(10); chk("R10", xsub_en, 0);
        rdout_fall = 1; cyc(1); rdout_fall = 0; chk("R10", xsub_en, 1);
        phase = "R1";
        shut_en = 0; cyc(1); chk("R1", xsub_en, 0);
        shut_en = 1; cyc(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL %s watchdog: got hung expected finished", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule